// File: doc/BRIEF.md
# Receive Bit Slipper with Polarity and Bit-Order Control

This block is one per-lane stage of a serial receive path. It sits in front of word alignment and takes fixed-width parallel words from the deserializer, each qualified by a valid strobe. Software control bits set three things. Polarity inversion complements every received bit. Bit-order reversal mirrors each output word. A slip control moves the word boundary by one bit position on every rising edge of its register bit, while the alignment enable is set.

The boundary shift works on two words: the previous accepted word and the current one. The block joins them and picks a window one word wide, starting at the current slip offset. A slip therefore never drops a word. It only disturbs the single output word in which the offset changes. The running offset is reported as a 5-bit count, so software can see how far the boundary has moved. Pattern search, line decoding and byte deserialisation belong to other stages.

Top module: `rx_bitslip_align`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_data` is 0 and `slip_count` is 0.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: A clock edge at which `ctl_slip` is 1, was 0 at the previous edge, and `ctl_align_en` is 1 increments `slip_count` by one. The new value is visible right after that edge.
- R4: While `ctl_slip` stays high over consecutive edges, `slip_count` does not change.
- R5: While `ctl_align_en` is 0, a rising `ctl_slip` leaves `slip_count` unchanged. The edge detector still tracks `ctl_slip`, so a slip bit that is already high when the enable is set causes no slip.
- R6: A slip taken while `slip_count` is W-1 (9 by default) makes it 0.
- R7: An accepted input word C, with P the previously accepted word, both taken after inversion, gives an output window equal to bits [k+W-1:k] of the 2W-bit value {C,P}. Here k is the slip count before that edge. With k=0 the output is P.
- R8: With `ctl_invert` set, every bit of an accepted input word is complemented before it enters the window.
- R9: With `ctl_reverse` set, output bit i equals window bit W-1-i. With it clear, output bit i equals window bit i.
- R10: An edge with `in_valid` low leaves `out_data` unchanged, and that word is not stored as the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | W | Parallel received word, bit 0 oldest |
| ctl_invert | input | 1 | Complement received bits |
| ctl_reverse | input | 1 | Mirror bit order of output words |
| ctl_align_en | input | 1 | Enables slip requests |
| ctl_slip | input | 1 | Slip request; each rising edge moves one bit |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | W | Realigned word |
| slip_count | output | 5 | Bits currently slipped |

## Verification
On every cycle the assertions check the counter rules: one step per accepted rising edge, no movement while the request is held or the enable is clear, and the wrap from W-1 to 0. They also check that the count stays below W, that the valid output lags the valid input by one cycle, and that invalid cycles leave the stored and output words alone. The bench alone can show that the bits of each output word are correct. It sweeps every slip offset under all four combinations of inversion and reversal, using a bench model of the two-word window. It also covers the held request and the disabled-enable cases.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int SLIP_CNT_W = 5;
  typedef logic [SLIP_CNT_W-1:0] slip_cnt_t;

  // next slip offset for a word of 'width' bits: wraps at width-1
  function automatic slip_cnt_t slip_advance(slip_cnt_t c, int unsigned width);
    if (c == slip_cnt_t'(width - 1)) return '0;
    return c + slip_cnt_t'(1);
  endfunction
endpackage

// File: rtl/rxs_polarity.sv
module rxs_polarity #(
  parameter int W = 10
) (
  input  logic         invert,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  assign dout = din ^ {W{invert}};
endmodule

// File: rtl/rxs_slip_ctrl.sv
module rxs_slip_ctrl
  import rxs_pkg::*;
#(
  parameter int W = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slip_req,
  input  logic      align_en,
  output slip_cnt_t count,
  output logic      slip_evt
);
  logic slip_q;

  // a slip happens only on a fresh rising edge with alignment enabled
  assign slip_evt = slip_req & ~slip_q & align_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_q <= 1'b0;
      count  <= '0;
    end else begin
      slip_q <= slip_req;
      if (slip_evt) count <= slip_advance(count, W);
    end
  end

  // R3 single step per accepted edge
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_evt && count != slip_cnt_t'(W-1)) |=> (count == $past(count) + slip_cnt_t'(1)));
  // R4 held request gives no further slips
  a_r4_held_no_slip: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_q && slip_req) |=> $stable(count));
  // R5 disabled alignment ignores requests
  a_r5_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!align_en) |=> $stable(count));
  // R6 wrap from W-1 to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_evt && count == slip_cnt_t'(W-1)) |=> (count == '0));
  // R6 offset never leaves the word
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    count < slip_cnt_t'(W));
endmodule

// File: rtl/rxs_window.sv
module rxs_window
  import rxs_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] cur,
  input  slip_cnt_t    offset,
  output logic [W-1:0] win
);
  logic [W-1:0] prev;
  logic [W-1:0] cand [W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev <= '0;
    else if (in_valid) prev <= cur;
  end

  // candidate k = bits [k+W-1:k] of {cur, prev}
  assign cand[0] = prev;
  for (genvar k = 1; k < W; k++) begin : g_cand
    assign cand[k] = {cur[k-1:0], prev[W-1:k]};
  end

  always_comb begin
    win = prev;
    for (int k = 0; k < W; k++) begin
      if (offset == slip_cnt_t'(k)) win = cand[k];
    end
  end

  // R10 invalid cycles do not replace the stored word
  a_r10_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(prev));
endmodule

// File: rtl/rxs_bitrev.sv
module rxs_bitrev #(
  parameter int W = 10
) (
  input  logic         reverse,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] mirrored;
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign mirrored[i] = din[W-1-i];
  end
  assign dout = reverse ? mirrored : din;
endmodule

// File: rtl/rx_bitslip_align.sv
module rx_bitslip_align
  import rxs_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [W-1:0]          in_data,
  input  logic                  ctl_invert,
  input  logic                  ctl_reverse,
  input  logic                  ctl_align_en,
  input  logic                  ctl_slip,
  output logic                  out_valid,
  output logic [W-1:0]          out_data,
  output logic [SLIP_CNT_W-1:0] slip_count
);
  logic [W-1:0] pol_word;
  logic [W-1:0] win_word;
  logic [W-1:0] fin_word;
  slip_cnt_t    offset;
  logic         slip_evt;
  logic         chk_armed;

  rxs_polarity #(.W(W)) u_pol (
    .invert(ctl_invert), .din(in_data), .dout(pol_word));

  rxs_slip_ctrl #(.W(W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .slip_req(ctl_slip), .align_en(ctl_align_en),
    .count(offset), .slip_evt(slip_evt));

  rxs_window #(.W(W)) u_win (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur(pol_word),
    .offset(offset), .win(win_word));

  rxs_bitrev #(.W(W)) u_rev (
    .reverse(ctl_reverse), .din(win_word), .dout(fin_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      chk_armed <= 1'b0;
    end else begin
      out_valid <= in_valid;
      chk_armed <= 1'b1;
      if (in_valid) out_data <= fin_word;
    end
  end

  assign slip_count = offset;

  // R2 fixed one-cycle valid latency
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed |-> (out_valid == $past(in_valid)));
  // R10 output word held on invalid cycles
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(out_data));
  // R3 count moves only after a slip event
  a_r3_move_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!slip_evt) |=> $stable(slip_count));
endmodule

// File: tb/rx_bitslip_align_test.sv
`timescale 1ns/1ps
module rx_bitslip_align_test;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic ctl_invert = 1'b0, ctl_reverse = 1'b0, ctl_align_en = 1'b0, ctl_slip = 1'b0;
  logic out_valid;
  logic [W-1:0] out_data;
  logic [4:0] slip_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [W-1:0] m_prev = '0;
  logic [W-1:0] m_out = '0;
  int m_cnt = 0;
  bit m_slipq = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  rx_bitslip_align #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .ctl_invert(ctl_invert), .ctl_reverse(ctl_reverse),
    .ctl_align_en(ctl_align_en), .ctl_slip(ctl_slip),
    .out_valid(out_valid), .out_data(out_data), .slip_count(slip_count));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] mirror(logic [W-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = d[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] next_word();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[W-1:0];
  endfunction

  // drive one cycle, compute expectations, check after the edge
  task automatic step(bit v, logic [W-1:0] d, bit slip);
    logic [W-1:0] dinv;
    logic [2*W-1:0] joined;
    logic [W-1:0] win;
    string ctag, dtag;
    bit evt;
    in_valid = v; in_data = d; ctl_slip = slip;
    dinv = d ^ {W{ctl_invert}};
    joined = {dinv, m_prev} >> m_cnt;
    win = joined[W-1:0];
    evt = slip && !m_slipq && ctl_align_en;
    if (evt) ctag = (m_cnt == W-1) ? "R6" : "R3";
    else if (slip && m_slipq) ctag = "R4";
    else if (slip && !ctl_align_en) ctag = "R5";
    else ctag = "R3";
    if (!v) dtag = "R10";
    else if (ctl_reverse) dtag = "R9";
    else if (ctl_invert) dtag = "R8";
    else dtag = "R7";
    if (v) begin
      m_out = ctl_reverse ? mirror(win) : win;
      m_prev = dinv;
    end
    if (evt) m_cnt = (m_cnt == W-1) ? 0 : m_cnt + 1;
    m_slipq = slip;
    @(posedge clk);
    #1;
    check("R2", 32'(out_valid), 32'(v));
    check(dtag, 32'(out_data), 32'(m_out));
    check(ctag, 32'(slip_count), 32'(m_cnt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 32'(out_valid), 0);
    check("R1", 32'(out_data), 0);
    check("R1", 32'(slip_count), 0);
    rst_n = 1'b1;
    ctl_align_en = 1'b1;

    // sweep every offset (and one wrap) under all polarity/order modes
    for (int mode = 0; mode < 4; mode++) begin
      ctl_invert = mode[0];
      ctl_reverse = mode[1];
      for (int off = 0; off <= W; off++) begin
        for (int n = 0; n < 6; n++) step(n != 3, next_word(), 1'b0);
        step(1'b1, next_word(), 1'b1);   // rising edge: slip
        step(1'b1, next_word(), 1'b1);   // held: no slip (R4)
        step(1'b0, next_word(), 1'b0);   // invalid cycle (R10)
      end
    end

    // R5: requests ignored while alignment disabled
    ctl_invert = 1'b0; ctl_reverse = 1'b0;
    ctl_align_en = 1'b0;
    step(1'b1, next_word(), 1'b0);
    step(1'b1, next_word(), 1'b1);
    step(1'b1, next_word(), 1'b0);
    step(1'b1, next_word(), 1'b1);
    ctl_align_en = 1'b1;                // already high: still no slip
    step(1'b1, next_word(), 1'b1);
    step(1'b1, next_word(), 1'b0);
    step(1'b1, next_word(), 1'b1);      // fresh edge now slips (R3)
    for (int n = 0; n < 4; n++) step(1'b1, next_word(), 1'b0);

    // R1 again: reset in mid-stream
    rst_n = 1'b0;
    #2;
    check("R1", 32'(out_valid), 0);
    check("R1", 32'(slip_count), 0);
    check("R1", 32'(out_data), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule